// File: doc/BRIEF.md
# Iterative Integer Divider

This unit computes signed and unsigned 32-bit quotients and remainders, one quotient bit per clock, using a restoring shift-subtract loop over operand magnitudes. A request carries a dividend, a divisor and a two-bit operation kind, which is the low two bits of the instruction's funct3 field. The unit returns one 32-bit word: either the quotient or the remainder. Signed results follow truncating division. The quotient rounds toward zero, and a nonzero remainder carries the dividend's sign.

A zero divisor, and the signed case of the most negative value divided by minus one, never enter the loop. They are recognised in the setup cycle, and their fixed results appear one edge after the request is taken. Every other request takes a setup cycle, 32 iteration cycles and one sign-fix cycle.

Both edges use a valid/ready handshake. A finished result is held until it is taken. A new request can be accepted on the same edge that the previous result leaves.

Top module: `idiv_unit`

## Requirements
- R1: `in_kind[1]` selects the remainder (1) or the quotient (0), and `in_kind[0]` selects unsigned (1) or signed (0) operands. Codes 00, 01, 10 and 11 are therefore signed quotient, unsigned quotient, signed remainder and unsigned remainder.
- R2: A signed quotient is the exact quotient truncated toward zero.
- R3: A signed remainder equals dividend minus quotient times divisor, so a nonzero remainder has the sign of the dividend.
- R4: Unsigned quotient and remainder treat both operands as values from 0 to 2^32-1.
- R5: A quotient with a zero divisor is 0xFFFFFFFF, for both signed and unsigned kinds.
- R6: A remainder with a zero divisor is the dividend, unchanged.
- R7: For the signed kinds, 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R8: For a zero divisor or a signed overflow, `out_valid` rises after the edge that follows the accepting edge. For any other request, it rises after the 34th edge that follows the accepting edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R10: `in_ready` is high when the unit is idle, and also when a result is held while `out_ready` is high. A request presented in that second case is accepted on the same edge that the result is taken.
- R11: An asserted `rst_n` drops `out_valid`, raises `in_ready` and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A request is presented |
| in_ready | output | 1 | The unit takes a request this cycle |
| in_kind | input | 2 | Operation kind: bit 1 selects remainder, bit 0 selects unsigned |
| in_a | input | 32 | Dividend |
| in_b | input | 32 | Divisor |
| out_valid | output | 1 | A result is held on out_data |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 32 | Quotient or remainder |

## Verification
Two functions can fall on the same edge: handing a finished result to the consumer and capturing the next request. The bench provokes this by presenting the next request as soon as the previous one is taken. The request then waits through the whole computation and meets the result while `out_ready` is high. Random stalls on `out_ready` also leave the request waiting against a held result. A behavioural model predicts `in_ready`, `out_valid` and `out_data` for every cycle. An edge where one result leaves and the next request enters is judged correct only if the old word is seen exactly until that edge, and the new word appears with the full latency after it.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  // Control states of the divider sequence.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_CALC = 3'd2,
    ST_FIX  = 3'd3,
    ST_DONE = 3'd4
  } idiv_state_e;

  // Operation kind, taken from the low two funct3 bits.
  typedef struct packed {
    logic rem_sel;   // 1: remainder, 0: quotient
    logic uns_sel;   // 1: unsigned operands
  } idiv_kind_t;

endpackage

// File: rtl/idiv_ctrl.sv
module idiv_ctrl
  import idiv_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic corner,
  output logic in_ready,
  output logic out_valid,
  output logic accept,
  output logic st_prep,
  output logic st_calc,
  output logic st_fix
);

  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  idiv_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last_step;

  assign last_step = (cnt_q == LAST);
  assign out_valid = (st_q == ST_DONE);
  assign in_ready  = (st_q == ST_IDLE) || ((st_q == ST_DONE) && out_ready);
  assign accept    = in_valid && in_ready;
  assign st_prep   = (st_q == ST_PREP);
  assign st_calc   = (st_q == ST_CALC);
  assign st_fix    = (st_q == ST_FIX);

  // Next-state decision.
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (in_valid) st_d = ST_PREP;
      ST_PREP: st_d = corner ? ST_DONE : ST_CALC;
      ST_CALC: if (last_step) st_d = ST_FIX;
      ST_FIX:  st_d = ST_DONE;
      ST_DONE: begin
        if (out_ready) st_d = in_valid ? ST_PREP : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Iteration counter: cleared in setup, advanced in each iteration.
  always_comb begin
    cnt_en = st_prep || st_calc;
    cnt_d  = st_prep ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R10: a taken request is never answered on the very next cycle.
  a_r10_accept_clears_valid: assert property (
    @(posedge clk) disable iff (!rst_n)
    accept |=> !out_valid
  ) else $error("a_r10_accept_clears_valid");

  // R8: a corner case flagged in setup is answered one edge later.
  a_r8_corner_fast: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_prep && corner) |=> out_valid
  ) else $error("a_r8_corner_fast");

  // R8: the sign-fix cycle is only reached from the iteration loop.
  a_r8_fix_after_loop: assert property (
    @(posedge clk) disable iff (!rst_n)
    st_fix |-> $past(st_calc)
  ) else $error("a_r8_fix_after_loop");

endmodule

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         rem_sel,
  input  logic         uns_sel,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         corner,
  output logic [W-1:0] corner_val
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic a_neg, b_neg, b_zero, ovf;

  always_comb begin
    a_neg  = !uns_sel && op_a[W-1];
    b_neg  = !uns_sel && op_b[W-1];
    a_mag  = a_neg ? (~op_a + 1'b1) : op_a;
    b_mag  = b_neg ? (~op_b + 1'b1) : op_b;
    // Truncating division: quotient sign from both operands,
    // remainder sign from the dividend only.
    neg_quo = a_neg ^ b_neg;
    neg_rem = a_neg;

    b_zero = (op_b == '0);
    ovf    = !uns_sel && (op_a == MOST_NEG) && (op_b == '1);
    corner = b_zero || ovf;

    if (b_zero) begin
      corner_val = rem_sel ? op_a : '1;
    end else begin
      corner_val = rem_sel ? '0 : MOST_NEG;
    end
  end

endmodule

// File: rtl/idiv_iter.sv
module idiv_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W:0]   trial, diff;
  logic         upd_en;

  // One restoring step: shift in the next dividend bit, try a subtract.
  always_comb begin
    trial  = {rem_q, quo_q[W-1]};
    diff   = trial - {1'b0, divisor};
    upd_en = load || step;
    quo_d  = quo_q;
    rem_d  = rem_q;
    if (load) begin
      quo_d = dividend;
      rem_d = '0;
    end else if (step) begin
      if (!diff[W]) begin
        rem_d = diff[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

  // R3: the partial remainder always stays below the divisor magnitude.
  a_r3_partial_below_divisor: assert property (
    @(posedge clk) disable iff (!rst_n)
    step |=> (rem_q < divisor)
  ) else $error("a_r3_partial_below_divisor");

endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
  import idiv_pkg::*;
#(
  parameter int W    = 32,
  parameter int ITER = W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_kind,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  idiv_kind_t   kind_q;
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] a_mag, b_mag, corner_val;
  logic         neg_quo, neg_rem, corner;
  logic         accept, st_prep, st_calc, st_fix;
  logic [W-1:0] quo, rem;
  logic [W-1:0] res_q, res_d, fixed_val;
  logic         res_en;

  idiv_ctrl #(.ITER(ITER)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .corner    (corner),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .accept    (accept),
    .st_prep   (st_prep),
    .st_calc   (st_calc),
    .st_fix    (st_fix)
  );

  idiv_prep #(.W(W)) u_prep (
    .op_a       (a_q),
    .op_b       (b_q),
    .rem_sel    (kind_q.rem_sel),
    .uns_sel    (kind_q.uns_sel),
    .a_mag      (a_mag),
    .b_mag      (b_mag),
    .neg_quo    (neg_quo),
    .neg_rem    (neg_rem),
    .corner     (corner),
    .corner_val (corner_val)
  );

  idiv_iter #(.W(W)) u_iter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (st_prep),
    .step     (st_calc),
    .dividend (a_mag),
    .divisor  (b_mag),
    .quo      (quo),
    .rem      (rem)
  );

  // Operand capture on the request handshake.
  always_ff @(posedge clk) begin
    if (accept) begin
      a_q    <= in_a;
      b_q    <= in_b;
      kind_q <= idiv_kind_t'(in_kind);
    end
  end

  // Result selection: fixed corner value in setup, signed fix-up after loop.
  always_comb begin
    if (kind_q.rem_sel) begin
      fixed_val = neg_rem ? (~rem + 1'b1) : rem;
    end else begin
      fixed_val = neg_quo ? (~quo + 1'b1) : quo;
    end
    res_en = (st_prep && corner) || st_fix;
    res_d  = st_fix ? fixed_val : corner_val;
  end

  always_ff @(posedge clk) begin
    if (res_en) begin
      res_q <= res_d;
    end
  end

  assign out_data = res_q;

  // R9: a held result neither vanishes nor changes until taken.
  a_r9_hold_stable: assert property (
    @(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))
  ) else $error("a_r9_hold_stable");

  // R5: a zero divisor gives an all-ones quotient.
  a_r5_zero_quotient: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_prep && (b_q == '0) && !kind_q.rem_sel) |=> (out_data == '1)
  ) else $error("a_r5_zero_quotient");

  // R6: a zero divisor gives back the dividend as remainder.
  a_r6_zero_remainder: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_prep && (b_q == '0) && kind_q.rem_sel) |=> (out_data == $past(a_q))
  ) else $error("a_r6_zero_remainder");

  // R7: signed overflow gives the most negative quotient or a zero remainder.
  a_r7_overflow: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_prep && !kind_q.uns_sel && (a_q == MOST_NEG) && (b_q == '1))
      |=> (out_data == ($past(kind_q.rem_sel) ? '0 : MOST_NEG))
  ) else $error("a_r7_overflow");

  // R2: a nonzero signed quotient is negative exactly when operand signs differ.
  a_r2_quotient_sign: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_fix && !kind_q.uns_sel && !kind_q.rem_sel && (quo != '0))
      |=> (out_data[W-1] == $past(a_q[W-1] ^ b_q[W-1]))
  ) else $error("a_r2_quotient_sign");

endmodule

// File: tb/idiv_unit_test.sv
`timescale 1ns/1ps
module idiv_unit_test;

  localparam int W    = 32;
  localparam int ITER = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   in_kind;
  logic [W-1:0] in_a, in_b;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit stall_en = 1'b0;
  bit run_done = 1'b0;

  // Behavioural model state: 0 idle, 1 busy, 2 result held.
  int          m_st = 0;
  int          m_left = 0;
  logic [31:0] m_exp = '0;
  logic [31:0] m_a = '0, m_b = '0;
  logic [1:0]  m_k = '0;
  bit          m_acc = 1'b0;
  bit          m_stall = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  idiv_unit #(.W(W), .ITER(ITER)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic bit is_corner(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    return (b == 0) || (!k[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
  endfunction

  // Expected result; kind bit 1 = remainder, bit 0 = unsigned (R1).
  function automatic logic [31:0] ref_res(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    if (b == 0) return k[1] ? a : 32'hFFFF_FFFF;
    if (k[0]) return k[1] ? (a % b) : (a / b);
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return k[1] ? 32'h0 : a;
    return k[1] ? 32'(sa % sb) : 32'(sa / sb);
  endfunction

  function automatic string tag_of(logic [1:0] k, logic [31:0] a, logic [31:0] b, bit st);
    if (st) return "R9";
    if (b == 0) return k[1] ? "R6" : "R5";
    if (!k[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R7";
    if (k[0]) return "R4";
    return k[1] ? "R3" : "R2";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model advances on each edge, from the inputs held since the previous one.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_acc = 1'b0; m_stall = 1'b0;
    end else begin
      bit rdy, acc;
      rdy = (m_st == 0) || (m_st == 2 && out_ready);
      acc = in_valid && rdy;
      m_stall = (m_st == 2) && !out_ready;
      if (m_st == 1) begin
        m_left--;
        if (m_left == 0) m_st = 2;
      end else if (m_st == 2 && out_ready) begin
        m_st = 0;
      end
      if (acc) begin
        m_st   = 1;
        m_a    = in_a; m_b = in_b; m_k = in_kind;
        m_left = is_corner(in_kind, in_a, in_b) ? 1 : ITER + 2;
        m_exp  = ref_res(in_kind, in_a, in_b);
      end
      m_acc = acc;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (!run_done) begin
      bit exp_rdy, exp_val;
      exp_rdy = (m_st == 0) || (m_st == 2 && out_ready);
      exp_val = (m_st == 2);
      if (rst_n !== 1'b1) begin
        chk(in_ready === 1'b1, "R11 in_ready in reset", 32'(in_ready), 32'd1);
        chk(out_valid === 1'b0, "R11 out_valid in reset", 32'(out_valid), 32'd0);
      end else begin
        chk(in_ready === exp_rdy, "R10 in_ready", 32'(in_ready), 32'(exp_rdy));
        chk(out_valid === exp_val, "R8 out_valid", 32'(out_valid), 32'(exp_val));
        if (exp_val)
          chk(out_data === m_exp,
              $sformatf("%s data (R1 kind=%0d a=%h b=%h)", tag_of(m_k, m_a, m_b, m_stall), m_k, m_a, m_b),
              out_data, m_exp);
      end
    end
  end

  // Consumer: random back-pressure when enabled.
  always begin
    @(posedge clk);
    #1;
    out_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
  end

  task automatic send(input logic [1:0] k, input logic [31:0] a, input logic [31:0] b);
    in_kind  = k;
    in_a     = a;
    in_b     = b;
    in_valid = 1'b1;
    do begin
      @(posedge clk);
      #1;
    end while (!m_acc);
    in_valid = 1'b0;
    if (stall_en && $urandom_range(3) == 0) begin
      repeat ($urandom_range(40)) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  task automatic drain();
    while (m_st != 0) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    run_done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  logic [31:0] dir_a [0:11];
  logic [31:0] dir_b [0:11];

  initial begin
    dir_a[0]  = 32'd7;          dir_b[0]  = 32'd2;
    dir_a[1]  = -32'sd7;        dir_b[1]  = 32'd2;
    dir_a[2]  = 32'd7;          dir_b[2]  = -32'sd2;
    dir_a[3]  = -32'sd7;        dir_b[3]  = -32'sd2;
    dir_a[4]  = 32'h1234_5678;  dir_b[4]  = 32'd0;
    dir_a[5]  = 32'h8000_0000;  dir_b[5]  = 32'hFFFF_FFFF;
    dir_a[6]  = 32'hFFFF_FFFF;  dir_b[6]  = 32'd1;
    dir_a[7]  = 32'd5;          dir_b[7]  = 32'd7;
    dir_a[8]  = 32'd0;          dir_b[8]  = 32'd3;
    dir_a[9]  = 32'h8000_0000;  dir_b[9]  = 32'd1;
    dir_a[10] = 32'hFFFF_FFF0;  dir_b[10] = 32'd0;
    dir_a[11] = 32'hDEAD_BEEF;  dir_b[11] = 32'h0001_0003;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_kind = '0; in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Directed: every kind over every vector, back to back (R10 overlap).
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 12; i++)
        send(2'(k), dir_a[i], dir_b[i]);

    // Random operands under random back-pressure (R9).
    stall_en = 1'b1;
    for (int n = 0; n < 80; n++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      case ($urandom_range(5))
        0: b = 32'd0;
        1: b = 32'hFFFF_FFFF;
        2: b = b >> 20;
        3: a = 32'h8000_0000;
        default: ;
      endcase
      send(2'($urandom_range(3)), a, b);
    end
    drain();

    // Reset in the middle of an operation (R11).
    stall_en = 1'b0;
    send(2'b00, 32'd1000, 32'd7);
    repeat (5) begin
      @(posedge clk);
      #1;
    end
    rst_n = 1'b0;
    repeat (2) begin
      @(posedge clk);
      #1;
    end
    rst_n = 1'b1;
    send(2'b11, 32'd1000, 32'd7);
    drain();
    repeat (3) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

endmodule